// File: doc/BRIEF.md
# Circular Bus-Cycle Trace Recorder

The recorder keeps a rolling history of processor bus cycles while an emulated program runs. On every qualified bus cycle it stores one entry holding the program counter, the instruction code, the data memory address, the data value and a register snapshot. Storage is a ring. Once the ring is full, each new entry replaces the oldest one, so the ring always holds the most recent stretch of execution.

A break pulse stops capture and freezes the ring. The host then reads entries by a logical trace pointer rather than by physical address. Pointer 0 is the oldest entry still held. Pointer `lvl-1` is the last cycle recorded before the break. `lvl` is the number of valid entries: it saturates at the ring depth and is smaller when the run was short. A run-start pulse empties the history and resumes capture.

The capture side has no back-pressure. Every `cap_valid` cycle is taken in the same cycle, or dropped when the recorder is halted. The read side is a request/response stream that is also never stalled. Each `rd_req` is accepted at once. Exactly one response arrives with `rd_valid` on the following cycle, so the host needs no ready signal.

Top module: `trace_recorder`

## Requirements
- R1: After reset the recorder is halted with `lvl` = 0, and any read returns `rd_hit` = 0.
- R2: While running, each cycle with `cap_valid` high stores one entry, and `lvl` rises by one in the cycle after it.
- R3: While halted, `cap_valid` has no effect: `lvl` and all stored entries are unchanged.
- R4: A `brk` pulse halts capture. A bus cycle presented in the same cycle as `brk` is not stored.
- R5: `lvl` saturates at DEPTH = 2^AW. Further captures overwrite the oldest entry and `lvl` stays at DEPTH.
- R6: A read with pointer `tp` < `lvl` returns the entry captured `lvl-1-tp` captures before the newest one. Pointer 0 is the oldest held entry and `lvl-1` is the newest.
- R7: A read with `tp` >= `lvl` returns `rd_hit` = 0 and all entry fields zero.
- R8: `rd_valid` is high exactly in the cycle after a cycle with `rd_req` high, and low otherwise. The entry and `rd_hit` are valid in that cycle.
- R9: `run_start` clears `lvl` to 0 and enters run mode. Capture then resumes in the following cycle, and a bus cycle presented with `run_start` is not stored.
- R10: If `run_start` and `brk` arrive in the same cycle, `lvl` is cleared and the recorder stays halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_start | input | 1 | Pulse: clear history and start capturing |
| brk | input | 1 | Pulse: stop capturing and freeze the ring |
| cap_valid | input | 1 | One bus cycle to record |
| cap_pc | input | PC_W | Program counter of the bus cycle |
| cap_op | input | OP_W | Instruction code |
| cap_daddr | input | DA_W | Data memory address |
| cap_data | input | DW | Data value |
| cap_regs | input | RG_W | Register snapshot |
| lvl | output | AW+1 | Number of valid entries |
| rd_req | input | 1 | Read request |
| rd_tp | input | AW | Logical trace pointer |
| rd_valid | output | 1 | Response strobe, one cycle after `rd_req` |
| rd_hit | output | 1 | Pointer was inside the valid range |
| rd_pc | output | PC_W | Returned program counter |
| rd_op | output | OP_W | Returned instruction code |
| rd_daddr | output | DA_W | Returned data address |
| rd_data | output | DW | Returned data value |
| rd_regs | output | RG_W | Returned register snapshot |

## Verification
A capture at a clock edge shows up in `lvl` right after that edge. A read request sampled at an edge has its response on `rd_valid`, `rd_hit` and the entry fields right after that same edge. The bench changes inputs on the falling edge and checks outputs on the next falling edge, which is exactly one rising edge later. Expected entries are regenerated from a global capture sequence number and the bench's own count of captures in the current run.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic {
    ST_HALT = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_start,
  input  logic          brk,
  input  logic          cap_valid,
  output logic          wr_en,
  output logic [AW-1:0] wptr,
  output logic [AW:0]   lvl
);
  import trace_pkg::*;
  localparam int        DEPTH = 1 << AW;
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  run_state_e state;

  assign wr_en = (state == ST_RUN) && cap_valid && !brk && !run_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HALT;
      wptr  <= '0;
      lvl   <= '0;
    end else begin
      if (run_start) begin
        lvl   <= '0;
        state <= brk ? ST_HALT : ST_RUN;
      end else if (brk) begin
        state <= ST_HALT;
      end
      if (wr_en) begin
        wptr <= wptr + 1'b1;
        if (lvl != FULL) lvl <= lvl + 1'b1;
      end
    end
  end

  AST_LVL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= FULL); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_valid && !run_start) |=> $stable(lvl)); // R3
  AST_BRK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !run_start) |=> $stable(lvl) && $stable(wptr)); // R4
  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (lvl == '0)); // R9
  AST_FULL_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == FULL && !run_start) |=> (lvl == FULL)); // R5
endmodule

// File: rtl/trace_ram.sv
module trace_ram #(
  parameter int AW = 11,
  parameter int W  = 84
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/trace_rdmap.sv
module trace_rdmap #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_tp,
  input  logic [AW-1:0] wptr,
  input  logic [AW:0]   lvl,
  output logic [AW-1:0] raddr,
  output logic          rd_valid,
  output logic          rd_hit
);
  logic in_range;

  assign in_range = ({1'b0, rd_tp} < lvl);
  assign raddr    = wptr - lvl[AW-1:0] + rd_tp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_hit   <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      rd_hit   <= rd_req && in_range;
    end
  end

  AST_RESP_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid); // R8
  AST_HIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && ({1'b0, rd_tp} >= lvl) |=> !rd_hit); // R7
endmodule

// File: rtl/trace_recorder.sv
module trace_recorder #(
  parameter int AW   = 11,
  parameter int PC_W = 16,
  parameter int OP_W = 16,
  parameter int DA_W = 16,
  parameter int DW   = 4,
  parameter int RG_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_start,
  input  logic            brk,
  input  logic            cap_valid,
  input  logic [PC_W-1:0] cap_pc,
  input  logic [OP_W-1:0] cap_op,
  input  logic [DA_W-1:0] cap_daddr,
  input  logic [DW-1:0]   cap_data,
  input  logic [RG_W-1:0] cap_regs,
  output logic [AW:0]     lvl,
  input  logic            rd_req,
  input  logic [AW-1:0]   rd_tp,
  output logic            rd_valid,
  output logic            rd_hit,
  output logic [PC_W-1:0] rd_pc,
  output logic [OP_W-1:0] rd_op,
  output logic [DA_W-1:0] rd_daddr,
  output logic [DW-1:0]   rd_data,
  output logic [RG_W-1:0] rd_regs
);
  localparam int EW = PC_W + OP_W + DA_W + DW + RG_W;

  logic          wr_en;
  logic [AW-1:0] wptr;
  logic [AW-1:0] raddr;
  logic [EW-1:0] wr_word;
  logic [EW-1:0] rd_word;
  logic [EW-1:0] out_word;

  assign wr_word = {cap_pc, cap_op, cap_daddr, cap_data, cap_regs};

  trace_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .brk(brk),
    .cap_valid(cap_valid), .wr_en(wr_en), .wptr(wptr), .lvl(lvl)
  );

  trace_ram #(.AW(AW), .W(EW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wptr), .wdata(wr_word),
    .re(rd_req), .raddr(raddr), .rdata(rd_word)
  );

  trace_rdmap #(.AW(AW)) u_map (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_tp(rd_tp),
    .wptr(wptr), .lvl(lvl), .raddr(raddr),
    .rd_valid(rd_valid), .rd_hit(rd_hit)
  );

  assign out_word = (rd_valid && rd_hit) ? rd_word : '0;
  assign {rd_pc, rd_op, rd_daddr, rd_data, rd_regs} = out_word;

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_hit) |-> (rd_pc == '0 && rd_regs == '0)); // R7
endmodule

// File: tb/sim_trace_recorder.sv
module sim_trace_recorder;
  localparam int CLK_T = 10;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_start = 0, brk = 0, cap_valid = 0, rd_req = 0;
  logic [15:0] cap_pc = 0, cap_op = 0, cap_daddr = 0;
  logic [3:0]  cap_data = 0;
  logic [31:0] cap_regs = 0;
  logic [AW-1:0] rd_tp = 0;
  logic [AW:0] lvl;
  logic rd_valid, rd_hit;
  logic [15:0] rd_pc, rd_op, rd_daddr;
  logic [3:0]  rd_data;
  logic [31:0] rd_regs;

  int n_chk = 0, n_bad = 0;
  int g = 0;          // global capture sequence number
  int run_first = 0;  // sequence number of first capture in current run
  int run_n = 0;      // captures in current run
  bit done = 0;

  always #(CLK_T/2) clk = ~clk;

  trace_recorder #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .brk(brk),
    .cap_valid(cap_valid), .cap_pc(cap_pc), .cap_op(cap_op),
    .cap_daddr(cap_daddr), .cap_data(cap_data), .cap_regs(cap_regs),
    .lvl(lvl), .rd_req(rd_req), .rd_tp(rd_tp), .rd_valid(rd_valid),
    .rd_hit(rd_hit), .rd_pc(rd_pc), .rd_op(rd_op), .rd_daddr(rd_daddr),
    .rd_data(rd_data), .rd_regs(rd_regs)
  );

  function automatic logic [83:0] pat(int s);
    logic [15:0] v = 16'(s);
    return {16'h1000 + v, v * 16'd3, ~v, v[3:0], {v, ~v}};
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_cap(int s);
    {cap_pc, cap_op, cap_daddr, cap_data, cap_regs} = pat(s);
    cap_valid = 1;
  endtask

  // n captures while running, with an idle gap after each odd capture
  task automatic capture(int n);
    for (int i = 0; i < n; i++) begin
      drive_cap(g);
      g++; run_n++;
      @(negedge clk);
      cap_valid = 0;
      if (i % 2 == 1) @(negedge clk);
    end
  endtask

  task automatic pulse_start();
    run_start = 1; @(negedge clk); run_start = 0;
    run_first = g; run_n = 0;
  endtask

  task automatic pulse_brk();
    brk = 1; @(negedge clk); brk = 0;
  endtask

  task automatic rd(int tp, output logic v, output logic h, output logic [83:0] w);
    rd_req = 1; rd_tp = AW'(tp);
    @(negedge clk);
    rd_req = 0;
    v = rd_valid; h = rd_hit;
    w = {rd_pc, rd_op, rd_daddr, rd_data, rd_regs};
  endtask

  function automatic int held();
    return (run_n < DEPTH) ? run_n : DEPTH;
  endfunction

  task automatic check_entry(string req, int tp);
    logic v, h; logic [83:0] w;
    rd(tp, v, h, w);
    chk({req, " valid"}, 128'(v), 128'(1));
    chk({req, " hit"}, 128'(h), 128'(1));
    chk({req, " entry"}, 128'(w), 128'(pat(run_first + run_n - held() + tp)));
  endtask

  task automatic t_reset();
    logic v, h; logic [83:0] w;
    chk("R1 lvl", 128'(lvl), 0);
    rd(0, v, h, w);
    chk("R1 hit", 128'(h), 0);
  endtask

  task automatic t_partial();
    logic v, h; logic [83:0] w;
    pulse_start();
    capture(5);
    chk("R2 lvl", 128'(lvl), 128'(5));
    pulse_brk();
    check_entry("R6 oldest", 0);
    check_entry("R6 newest", 4);
    check_entry("R6 middle", 2);
    rd(5, v, h, w);
    chk("R7 hit", 128'(h), 0);
    chk("R7 zero", 128'(w), 0);
  endtask

  task automatic t_halted();
    drive_cap(999); @(negedge clk); @(negedge clk); cap_valid = 0;
    chk("R3 lvl", 128'(lvl), 128'(5));
    check_entry("R3 content", 4);
  endtask

  task automatic t_latency();
    @(negedge clk);
    chk("R8 idle", 128'(rd_valid), 0);
    rd_req = 1; rd_tp = 0;
    chk("R8 same cycle", 128'(rd_valid), 0);
    @(negedge clk); rd_req = 0;
    chk("R8 next cycle", 128'(rd_valid), 1);
    @(negedge clk);
    chk("R8 drop", 128'(rd_valid), 0);
  endtask

  task automatic t_break_cycle();
    pulse_start();
    chk("R9 clear", 128'(lvl), 0);
    capture(3);
    drive_cap(777); brk = 1;
    @(negedge clk); brk = 0; cap_valid = 0;
    chk("R4 lvl", 128'(lvl), 128'(3));
    check_entry("R4 newest", 2);
  endtask

  task automatic t_wrap();
    pulse_start();
    capture(DEPTH + 7);
    chk("R5 lvl", 128'(lvl), 128'(DEPTH));
    pulse_brk();
    check_entry("R5 oldest", 0);
    check_entry("R5 newest", DEPTH - 1);
    check_entry("R6 wrap mid", 9);
  endtask

  task automatic t_start_brk();
    run_start = 1; brk = 1;
    @(negedge clk); run_start = 0; brk = 0;
    run_first = g; run_n = 0;
    chk("R10 clear", 128'(lvl), 0);
    drive_cap(555); @(negedge clk); cap_valid = 0;
    chk("R10 halted", 128'(lvl), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_partial();
    t_halted();
    t_latency();
    t_break_cycle();
    t_wrap();
    t_start_brk();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule